// File: doc/BRIEF.md
# Command List DMA Walker

This block is a read-only DMA engine. It fetches 32-bit command words from system RAM and delivers them, one at a time and in order, to a graphics command port. A one-cycle start pulse launches a job and samples four inputs along with it: a 32-bit control word, a base address, a block size and a block count. A one-cycle done pulse marks the end of the job. From start to done the channel reports busy.

The control word picks one of two walking modes. In sequential mode the engine streams the product of block size and block count as consecutive words, going upward from the base address. In chained mode it follows a list of packets. Each packet begins with a header word. The header's most significant byte gives the number of payload words that follow it. Bit 23 of the header marks the last packet. The low 21 bits of the header point to the next header. Each address the engine issues is confined to a 21-bit space.

The engine issues one memory read at a time. It does not start the read for the next word until the command port has taken the current word.

Top module: `cmd_dma_walker`

## Requirements
- R1: A control word of 0x01000401 selects chained mode and 0x01000201 selects sequential mode. Any other control word ends the job immediately: done_o is high one cycle after start, with no memory read and no command word.
- R2: The first address the engine reads is base_i with bits 31..21 cleared.
- R3: In chained mode, header bits 31..24 give the number N of payload words. The engine reads those N words from the header address + 4 upward, in 4-byte steps, and forwards them in that order.
- R4: After the payload of a header, if header bit 23 is 1 the walk ends. Otherwise the next header is read at header bits 20..0, and all other header bits are ignored for that address.
- R5: A header with N = 0 forwards no words, but its end bit and next pointer are still honoured. If the end bit is set, done_o rises 3 cycles after the start cycle when memory answers in the cycle after the request.
- R6: In sequential mode the engine forwards blk_size_i × blk_cnt_i words, read upward in 4-byte steps from the start address. A product of zero ends the job one cycle after start with no read.
- R7: While cmd_valid_o is high and cmd_ready_i is low, cmd_valid_o stays high and cmd_data_o stays unchanged in the next cycle.
- R8: mem_req_o is never high while cmd_valid_o is high.
- R9: done_o is a single-cycle pulse. busy_o is high from the cycle after an accepted start up to and including the done cycle, and low in the cycle after it. A start pulse while busy_o is high is ignored.
- R10: After reset, mem_req_o, cmd_valid_o, busy_o and done_o are all low.
- R11: A memory request stays high with a stable address until mem_valid_i returns the data.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Job launch pulse; samples the configuration inputs |
| ctrl_i | input | 32 | Channel control word; selects the mode |
| base_i | input | 32 | Start address before masking |
| blk_size_i | input | 16 | Words per block (sequential mode) |
| blk_cnt_i | input | 16 | Number of blocks (sequential mode) |
| mem_req_o | output | 1 | Memory read request |
| mem_addr_o | output | 32 | Byte address of the read, upper bits zero |
| mem_valid_i | input | 1 | Read data valid, one cycle per request |
| mem_data_i | input | 32 | Read data |
| cmd_valid_o | output | 1 | Command word available |
| cmd_data_o | output | 32 | Command word |
| cmd_ready_i | input | 1 | Command port accepts the word |
| busy_o | output | 1 | Job in progress |
| done_o | output | 1 | Job finished, one-cycle pulse |

## Verification
A job with an unknown control word, or with a zero sequential length, must show done_o at the first falling edge after the start edge. A header-only list whose first header ends the walk, served by a memory that answers one cycle after the request, must show done_o at the third falling edge. The bench counts falling edges from the start pulse and compares against those exact figures. Every command word is due one cycle after its memory data returns, and it is held until the port accepts it. The bench therefore compares words only at accepted handshakes, against a queue that the job setup fills from its own model of the list. At every stall it checks that the word is held unchanged into the next cycle. At the done pulse it also checks that the queue is empty, and one cycle later that busy_o has dropped.

// File: rtl/cdw_pkg.sv
package cdw_pkg;
  localparam logic [31:0] CTRL_LIST = 32'h0100_0401;
  localparam logic [31:0] CTRL_SEQ  = 32'h0100_0201;
  localparam int unsigned HDR_END_BIT = 23;

  typedef enum logic [1:0] {MODE_BAD, MODE_LIST, MODE_SEQ} mode_e;
  typedef enum logic [2:0] {ST_IDLE, ST_HDR, ST_PAY, ST_HOLD, ST_DONE} state_e;
endpackage

// File: rtl/cdw_mode_decode.sv
module cdw_mode_decode
  import cdw_pkg::*;
(
  input  logic [31:0] ctrl_i,
  output mode_e       mode_o
);
  always_comb begin
    unique case (ctrl_i)
      CTRL_LIST: mode_o = MODE_LIST;
      CTRL_SEQ:  mode_o = MODE_SEQ;
      default:   mode_o = MODE_BAD;
    endcase
  end
endmodule

// File: rtl/cdw_len_cnt.sv
module cdw_len_cnt #(
  parameter int unsigned CNT_W = 32
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             load_i,
  input  logic [CNT_W-1:0] val_i,
  input  logic             dec_i,
  output logic             last_o
);
  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     cnt_q <= '0;
    else if (load_i) cnt_q <= val_i;
    else if (dec_i)  cnt_q <= cnt_q - 1'b1;
  end

  assign last_o = (cnt_q == CNT_W'(1));
endmodule

// File: rtl/cdw_cmd_slot.sv
module cdw_cmd_slot #(
  parameter int unsigned DW = 32
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          load_i,
  input  logic [DW-1:0] data_i,
  input  logic          ready_i,
  output logic          valid_o,
  output logic [DW-1:0] data_o,
  output logic          accept_o
);
  assign accept_o = valid_o & ready_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_o <= 1'b0;
      data_o  <= '0;
    end else if (load_i) begin
      valid_o <= 1'b1;
      data_o  <= data_i;
    end else if (accept_o) begin
      valid_o <= 1'b0;
    end
  end
endmodule

// File: rtl/cmd_dma_walker.sv
module cmd_dma_walker
  import cdw_pkg::*;
#(
  parameter int unsigned AW    = 21,
  parameter int unsigned DW    = 32,
  parameter int unsigned CNT_W = 32
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          start_i,
  input  logic [31:0]   ctrl_i,
  input  logic [DW-1:0] base_i,
  input  logic [15:0]   blk_size_i,
  input  logic [15:0]   blk_cnt_i,
  output logic          mem_req_o,
  output logic [DW-1:0] mem_addr_o,
  input  logic          mem_valid_i,
  input  logic [DW-1:0] mem_data_i,
  output logic          cmd_valid_o,
  output logic [DW-1:0] cmd_data_o,
  input  logic          cmd_ready_i,
  output logic          busy_o,
  output logic          done_o
);
  localparam logic [DW-1:0] ADDR_MASK = DW'((64'd1 << AW) - 64'd1);
  localparam logic [DW-1:0] STEP      = DW'(4);

  state_e           state_q;
  logic             list_q;
  logic [DW-1:0]    addr_q;
  logic [DW-1:0]    hdr_q;
  mode_e            mode;
  logic [CNT_W-1:0] seq_words;
  logic [CNT_W-1:0] hdr_len;
  logic [CNT_W-1:0] cnt_val;
  logic             cnt_load, cnt_dec, cnt_last;
  logic             slot_load, accept;
  logic             launch;
  logic [DW-1:0]    addr_inc;

  cdw_mode_decode i_dec (.ctrl_i(ctrl_i), .mode_o(mode));

  assign seq_words = CNT_W'(blk_size_i) * CNT_W'(blk_cnt_i);
  assign hdr_len   = CNT_W'(mem_data_i[DW-1:DW-8]);
  assign addr_inc  = (addr_q + STEP) & ADDR_MASK;
  assign launch    = (state_q == ST_IDLE) && start_i;

  always_comb begin
    cnt_load  = (launch && mode == MODE_SEQ) || (state_q == ST_HDR && mem_valid_i);
    cnt_val   = (state_q == ST_IDLE) ? seq_words : hdr_len;
    cnt_dec   = (state_q == ST_HOLD) && accept;
    slot_load = (state_q == ST_PAY) && mem_valid_i;
  end

  cdw_len_cnt #(.CNT_W(CNT_W)) i_cnt (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .load_i (cnt_load),
    .val_i  (cnt_val),
    .dec_i  (cnt_dec),
    .last_o (cnt_last)
  );

  cdw_cmd_slot #(.DW(DW)) i_slot (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .load_i   (slot_load),
    .data_i   (mem_data_i),
    .ready_i  (cmd_ready_i),
    .valid_o  (cmd_valid_o),
    .data_o   (cmd_data_o),
    .accept_o (accept)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      list_q  <= 1'b0;
      addr_q  <= '0;
      hdr_q   <= '0;
    end else begin
      unique case (state_q)
        ST_IDLE: if (start_i) begin
          addr_q <= base_i & ADDR_MASK;
          list_q <= (mode == MODE_LIST);
          unique case (mode)
            MODE_LIST: state_q <= ST_HDR;
            MODE_SEQ:  state_q <= (seq_words == '0) ? ST_DONE : ST_PAY;
            default:   state_q <= ST_DONE;
          endcase
        end
        ST_HDR: if (mem_valid_i) begin
          hdr_q <= mem_data_i;
          if (hdr_len != '0) begin
            addr_q  <= addr_inc;
            state_q <= ST_PAY;
          end else if (mem_data_i[HDR_END_BIT]) begin
            state_q <= ST_DONE;
          end else begin
            addr_q <= mem_data_i & ADDR_MASK;  // empty packet: chain on
          end
        end
        ST_PAY: if (mem_valid_i) begin
          addr_q  <= addr_inc;
          state_q <= ST_HOLD;
        end
        ST_HOLD: if (accept) begin
          if (!cnt_last)                 state_q <= ST_PAY;
          else if (!list_q)              state_q <= ST_DONE;
          else if (hdr_q[HDR_END_BIT])   state_q <= ST_DONE;
          else begin
            addr_q  <= hdr_q & ADDR_MASK;
            state_q <= ST_HDR;
          end
        end
        ST_DONE: state_q <= ST_IDLE;
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign mem_req_o  = (state_q == ST_HDR) || (state_q == ST_PAY);
  assign mem_addr_o = addr_q;
  assign busy_o     = (state_q != ST_IDLE);
  assign done_o     = (state_q == ST_DONE);
endmodule

// File: rtl/cdw_checker.sv
module cdw_checker
  import cdw_pkg::*;
#(
  parameter int unsigned AW = 21,
  parameter int unsigned DW = 32
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic          start_i,
  input logic [31:0]   ctrl_i,
  input logic [DW-1:0] base_i,
  input logic          mem_req_o,
  input logic [DW-1:0] mem_addr_o,
  input logic          mem_valid_i,
  input logic          cmd_valid_o,
  input logic [DW-1:0] cmd_data_o,
  input logic          cmd_ready_i,
  input logic          busy_o,
  input logic          done_o
);
  localparam logic [DW-1:0] MASK = DW'((64'd1 << AW) - 64'd1);

  AST_BAD_CTRL_ENDS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_i && !busy_o && ctrl_i != CTRL_LIST && ctrl_i != CTRL_SEQ |=> done_o && !mem_req_o); // R1
  AST_FIRST_ADDR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_i && !busy_o && ctrl_i == CTRL_LIST |=> mem_req_o && mem_addr_o == ($past(base_i) & MASK)); // R2
  AST_CMD_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cmd_valid_o && !cmd_ready_i |=> cmd_valid_o && $stable(cmd_data_o)); // R7
  AST_NO_READ_PENDING: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cmd_valid_o |-> !mem_req_o); // R8
  AST_DONE_PULSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o && !busy_o); // R9
  AST_DONE_IN_BUSY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> busy_o); // R9
  AST_REQ_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_req_o && !mem_valid_i |=> mem_req_o && $stable(mem_addr_o)); // R11
endmodule

bind cmd_dma_walker cdw_checker #(.AW(AW), .DW(DW)) i_cdw_checker (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .start_i     (start_i),
  .ctrl_i      (ctrl_i),
  .base_i      (base_i),
  .mem_req_o   (mem_req_o),
  .mem_addr_o  (mem_addr_o),
  .mem_valid_i (mem_valid_i),
  .cmd_valid_o (cmd_valid_o),
  .cmd_data_o  (cmd_data_o),
  .cmd_ready_i (cmd_ready_i),
  .busy_o      (busy_o),
  .done_o      (done_o)
);

// File: tb/test_cmd_dma_walker.sv
`timescale 1ns/1ps
module test_cmd_dma_walker;
  localparam logic [31:0] C_LIST = 32'h0100_0401;
  localparam logic [31:0] C_SEQ  = 32'h0100_0201;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic [31:0] ctrl = '0, base = '0;
  logic [15:0] bsz = '0, bcnt = '0;
  logic        mem_req, mem_valid = 1'b0;
  logic [31:0] mem_addr, mem_data = '0;
  logic        cmd_valid, cmd_ready;
  logic [31:0] cmd_data;
  logic        busy, done;

  logic [31:0] mem [0:1023];
  logic [31:0] expq [$];
  int          n_tests = 0, n_fail = 0;
  int          mem_lat = 0, wcnt = 0;
  bit          stall_en = 1'b0;
  logic [7:0]  lfsr = 8'hA1;
  logic        prev_hold = 1'b0;
  logic [31:0] prev_data = '0;

  always #10 clk = ~clk;

  cmd_dma_walker i_cmd_dma_walker (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start), .ctrl_i(ctrl), .base_i(base),
    .blk_size_i(bsz), .blk_cnt_i(bcnt), .mem_req_o(mem_req), .mem_addr_o(mem_addr),
    .mem_valid_i(mem_valid), .mem_data_i(mem_data), .cmd_valid_o(cmd_valid),
    .cmd_data_o(cmd_data), .cmd_ready_i(cmd_ready), .busy_o(busy), .done_o(done)
  );

  task automatic chk(input bit ok, input string rq, input logic [31:0] act, input logic [31:0] exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", rq, act, exp);
    end
  endtask

  // memory model: answers after mem_lat extra cycles, one valid per request
  always @(posedge clk) begin
    if (mem_valid) mem_valid <= 1'b0;
    else if (mem_req && rst_n) begin
      if (wcnt >= mem_lat) begin
        mem_valid <= 1'b1;
        mem_data  <= mem[mem_addr[11:2]];
        wcnt      <= 0;
      end else wcnt <= wcnt + 1;
    end
  end

  always @(posedge clk) lfsr <= {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
  assign cmd_ready = stall_en ? lfsr[0] : 1'b1;

  // monitor: scoreboard compare at handshakes, hold and read-ordering checks
  always @(negedge clk) begin
    if (rst_n) begin
      if (prev_hold) chk(cmd_valid && cmd_data == prev_data, "R7 hold", cmd_data, prev_data);
      if (cmd_valid && mem_req) chk(1'b0, "R8 read while word pending", {31'd0, mem_req}, 32'd0);
      if (cmd_valid && cmd_ready) begin
        if (expq.size() == 0) chk(1'b0, "R3/R6 unexpected word", cmd_data, 32'hxxxx_xxxx);
        else begin
          logic [31:0] e;
          e = expq.pop_front();
          chk(cmd_data == e, "R3/R6 word order", cmd_data, e);
        end
      end
      prev_hold = cmd_valid && !cmd_ready;
      prev_data = cmd_data;
    end
  end

  task automatic launch(input logic [31:0] c, input logic [31:0] b, input logic [15:0] s, input logic [15:0] n);
    @(negedge clk);
    ctrl = c; base = b; bsz = s; bcnt = n; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
  endtask

  task automatic wait_done(output int cyc);
    cyc = 1;
    while (!done && cyc < 4000) begin
      @(negedge clk);
      cyc++;
    end
  endtask

  task automatic finish_job(input string rq);
    chk(done, {rq, " done seen"}, {31'd0, done}, 32'd1);
    chk(expq.size() == 0, {rq, " all words sent"}, expq.size(), 32'd0);
    @(negedge clk);
    chk(!done && !busy, "R9 done one cycle, busy drops", {30'd0, done, busy}, 32'd0);
  endtask

  initial begin
    int cyc;
    for (int i = 0; i < 1024; i++) mem[i] = 32'hC0DE_0000 | i;
    // list: 0x100 (2 words, next 0x200), 0x200 (empty, next 0x300), 0x300 (3 words, end)
    mem[32'h100 >> 2] = 32'h0260_0200;   // bits 22:21 set: ignored in pointer (R4)
    mem[32'h200 >> 2] = 32'h0000_0300;
    mem[32'h300 >> 2] = 32'h0380_0100;   // end bit set, pointer ignored
    mem[32'h500 >> 2] = 32'h0080_0000;   // empty and last

    repeat (3) @(negedge clk);
    chk(!mem_req && !cmd_valid && !busy && !done, "R10 reset outputs",
        {28'd0, mem_req, cmd_valid, busy, done}, 32'd0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(!busy && !mem_req, "R10 idle after reset", {30'd0, busy, mem_req}, 32'd0);

    // R3 R4 R5 R2: chained walk with stalls on both sides
    mem_lat = 2; stall_en = 1'b1;
    expq.push_back(mem[32'h104 >> 2]); expq.push_back(mem[32'h108 >> 2]);
    expq.push_back(mem[32'h304 >> 2]); expq.push_back(mem[32'h308 >> 2]);
    expq.push_back(mem[32'h30C >> 2]);
    launch(C_LIST, 32'hFFE0_0100, 16'd0, 16'd0);
    chk(busy && mem_req && mem_addr == 32'h100, "R2 masked first address", mem_addr, 32'h100);
    wait_done(cyc);
    finish_job("R4");

    // R5: header-only, last, memory answering next cycle -> done at 3rd cycle
    mem_lat = 0; stall_en = 1'b0;
    launch(C_LIST, 32'h0000_0500, 16'd0, 16'd0);
    wait_done(cyc);
    chk(cyc == 3, "R5 empty last header timing", cyc, 32'd3);
    finish_job("R5");

    // R6 R9: sequential 3x2 words from masked base, start while busy ignored
    mem_lat = 1;
    for (int i = 0; i < 6; i++) expq.push_back(mem[(32'h400 >> 2) + i]);
    launch(C_SEQ, 32'h7FE0_0400, 16'd3, 16'd2);
    chk(mem_req && mem_addr == 32'h400, "R6 sequential start address", mem_addr, 32'h400);
    repeat (3) @(negedge clk);
    ctrl = 32'h0; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    chk(!done && busy, "R9 start while busy ignored", {30'd0, done, busy}, 32'd1);
    wait_done(cyc);
    finish_job("R6");

    // R6: zero length sequential ends at once
    launch(C_SEQ, 32'h0000_0400, 16'd0, 16'd5);
    chk(done && !mem_req, "R6 zero length ends", {30'd0, done, mem_req}, 32'd2);
    finish_job("R6 zero");

    // R1: unknown control word
    launch(32'h0100_0200, 32'h0000_0400, 16'd4, 16'd4);
    chk(done && !mem_req && !cmd_valid, "R1 unknown control", {29'd0, done, mem_req, cmd_valid}, 32'd4);
    finish_job("R1");

    // R3 with heavy back-pressure, single packet straight to end
    mem[32'h600 >> 2] = 32'h0480_0000;
    for (int i = 1; i <= 4; i++) expq.push_back(mem[(32'h600 >> 2) + i]);
    stall_en = 1'b1; mem_lat = 3;
    launch(C_LIST, 32'h0020_0600, 16'd0, 16'd0);
    wait_done(cyc);
    finish_job("R3");

    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    n_tests++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule